// File: doc/BRIEF.md
# Clock and Power Supervision Interrupt Status Unit

This unit gathers seven clock and power supervision events into one processor interrupt. Each event input is a one-cycle pulse from a detector outside this block. The pulse sets a sticky raw status bit. A read/write enable register chooses which of the raw bits reach the processor. A third register presents the enabled bits, and software clears events by writing ones to that register. The interrupt line is the registered OR of the enabled bits.

A control register holds one routing bit for the brown-out event. When that bit is set, brown-out is handled as a reset elsewhere. The raw brown-out bit still records the event, but it is kept out of the enabled view and off the interrupt line. Software reaches all registers through a plain register port with a byte address, a write strobe, write data and registered read data.

Top module: `sysctl_irq_status`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: A 1 on bit i of `evt` sets raw status bit i, and the bit stays set until it is cleared. Bit 0 is PLL fault, 1 is brown-out, 2 is LDO unregulated, 3 is main oscillator fault, 4 is internal oscillator fault, 5 is LDO current limit and 6 is PLL lock. Raw status reads at offset 0x050 in bits 6:0, and writes to 0x050 have no effect.
- R3: The enable register at offset 0x054 is read/write in bits 6:0.
- R4: The masked status at offset 0x058 reads raw AND enable in bits 6:0. Bit 1 also requires the routing bit to be 0.
- R5: Writing to 0x058 clears each raw bit whose write-data bit is 1. Write-data bits that are 0 leave their raw bits unchanged.
- R6: If an event and a clear reach the same raw bit in the same cycle, the bit ends up set.
- R7: Bit 1 of the control register at offset 0x030 is read/write. While it is 1, masked bit 1 reads 0 and brown-out does not raise `irq`, but the raw brown-out bit is still set by its event.
- R8: `irq` is the OR of masked bits 6:0 as they stood in the previous cycle.
- R9: Reserved bits read 0, and writes to them are ignored. Addresses with no register read 0.
- R10: `rdata` shows, one clock after the address is presented, the addressed register as it stood before that clock edge. `rdata` holds its value until the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | 7 | Event pulses, one per supervision event |
| addr | input | 12 | Register byte address |
| we | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
Assertions check on every cycle that:
- raw bits are sticky;
- an event always leaves its raw bit set;
- `irq` follows the previous cycle's masked OR;
- the routed brown-out bit never appears in the masked view;
- reserved read bits stay 0.

The bench scenarios are needed for the rest:
- the register address decode;
- the exact masked value for each raw, enable and routing combination;
- partial clears;
- writes that are ignored;
- the one-cycle read latency.

These are swept over every raw pattern.

// File: rtl/sysirq_pkg.sv
package sysirq_pkg;
  localparam int NUM_EVT   = 7;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 12;
  localparam int OFS_CTRL  = 'h030;
  localparam int OFS_RAW   = 'h050;
  localparam int OFS_EN    = 'h054;
  localparam int OFS_MSK   = 'h058;
  localparam int BIT_BOR   = 1;   // brown-out event position
  localparam int BIT_ROUTE = 1;   // routing bit position in control register
endpackage

// File: rtl/sysirq_raw_capture.sv
module sysirq_raw_capture #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] raw
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         raw[i] <= 1'b0;
      else if (evt[i]) raw[i] <= 1'b1;   // set has priority
      else if (clr[i]) raw[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sysirq_cfg_regs.sv
module sysirq_cfg_regs #(
  parameter int N         = 7,
  parameter int AW        = 12,
  parameter int EN_OFS    = 'h054,
  parameter int CTRL_OFS  = 'h030,
  parameter int ROUTE_BIT = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [AW-1:0] addr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] en_q,
  output logic         route_q
);
  localparam logic [AW-1:0] A_EN   = AW'(EN_OFS);
  localparam logic [AW-1:0] A_CTRL = AW'(CTRL_OFS);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      route_q <= 1'b0;
    end else if (we) begin
      if (addr == A_EN)   en_q    <= wbits;
      if (addr == A_CTRL) route_q <= wbits[ROUTE_BIT];
    end
  end
endmodule

// File: rtl/sysirq_read_mux.sv
module sysirq_read_mux #(
  parameter int N         = 7,
  parameter int DW        = 32,
  parameter int AW        = 12,
  parameter int RAW_OFS   = 'h050,
  parameter int EN_OFS    = 'h054,
  parameter int MSK_OFS   = 'h058,
  parameter int CTRL_OFS  = 'h030,
  parameter int ROUTE_BIT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [N-1:0]  raw,
  input  logic [N-1:0]  en,
  input  logic [N-1:0]  masked,
  input  logic          route,
  output logic [DW-1:0] rdata
);
  localparam logic [AW-1:0] A_RAW  = AW'(RAW_OFS);
  localparam logic [AW-1:0] A_EN   = AW'(EN_OFS);
  localparam logic [AW-1:0] A_MSK  = AW'(MSK_OFS);
  localparam logic [AW-1:0] A_CTRL = AW'(CTRL_OFS);

  logic [DW-1:0] sel;
  always_comb begin
    sel = '0;
    unique case (addr)
      A_RAW:   sel[N-1:0] = raw;
      A_EN:    sel[N-1:0] = en;
      A_MSK:   sel[N-1:0] = masked;
      A_CTRL:  sel[ROUTE_BIT] = route;
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end
endmodule

// File: rtl/sysctl_irq_status.sv
module sysctl_irq_status
  import sysirq_pkg::*;
#(
  parameter int N  = NUM_EVT,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  evt,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_MSK = AW'(OFS_MSK);

  logic [N-1:0] raw_q, en_q, clr_v, masked_v, supp_v;
  logic         route_q;
  logic         unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DW-1:N];
  assign clr_v = (we && addr == A_MSK) ? wdata[N-1:0] : '0;

  sysirq_raw_capture #(.N(N)) u_raw (
    .clk(clk), .rst(rst), .evt(evt), .clr(clr_v), .raw(raw_q)
  );

  sysirq_cfg_regs #(
    .N(N), .AW(AW), .EN_OFS(OFS_EN), .CTRL_OFS(OFS_CTRL), .ROUTE_BIT(BIT_ROUTE)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(we), .addr(addr), .wbits(wdata[N-1:0]),
    .en_q(en_q), .route_q(route_q)
  );

  always_comb begin
    supp_v          = '0;
    supp_v[BIT_BOR] = route_q;
    masked_v        = raw_q & en_q & ~supp_v;
  end

  sysirq_read_mux #(
    .N(N), .DW(DW), .AW(AW), .RAW_OFS(OFS_RAW), .EN_OFS(OFS_EN),
    .MSK_OFS(OFS_MSK), .CTRL_OFS(OFS_CTRL), .ROUTE_BIT(BIT_ROUTE)
  ) u_rd (
    .clk(clk), .rst(rst), .addr(addr), .raw(raw_q), .en(en_q),
    .masked(masked_v), .route(route_q), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |masked_v;
  end
endmodule

// File: rtl/sysirq_chk.sv
module sysirq_chk #(
  parameter int N  = 7,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  evt,
  input logic [N-1:0]  raw,
  input logic [N-1:0]  clr,
  input logic [N-1:0]  masked,
  input logic          route,
  input logic          irq,
  input logic [DW-1:0] rdata
);
  // R2: a raw bit only drops when a clear reached it
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(raw) & ~$past(clr)) & ~raw) == '0));

  // R6: an event always leaves its bit set, clear or not
  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((raw & $past(evt)) == $past(evt)));

  // R8: interrupt follows previous masked OR
  a_r8_irq_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|masked)));

  // R7: routed brown-out never shows in masked view
  a_r7_bor_routed: assert property (@(posedge clk) disable iff (rst)
    route |-> !masked[1]);

  // R9: reserved read bits stay zero
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    rdata[DW-1:N] == '0);
endmodule

bind sysctl_irq_status sysirq_chk #(.N(N), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .evt(evt), .raw(raw_q), .clr(clr_v),
  .masked(masked_v), .route(route_q), .irq(irq), .rdata(rdata)
);

// File: tb/sim_sysctl_irq_status.sv
`timescale 1ns/1ps
module sim_sysctl_irq_status;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  evt = '0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sysctl_irq_status u0 (
    .clk(clk), .rst(rst), .evt(evt), .addr(addr), .we(we),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    @(negedge clk); d = rdata;
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [6:0]  m, e;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(12'h050, v); chk("R1 raw", v, 0);
    rd(12'h054, v); chk("R1 en", v, 0);
    rd(12'h058, v); chk("R1 masked", v, 0);
    rd(12'h030, v); chk("R1 ctrl", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R3, R9 enable register and reserved bits
    wr(12'h054, 32'hFFFF_FFFF); rd(12'h054, v); chk("R3 R9 en all ones", v, 32'h7F);
    wr(12'h054, 32'h0000_0035); rd(12'h054, v); chk("R3 en pattern", v, 32'h35);
    wr(12'h030, 32'hFFFF_FFFF); rd(12'h030, v); chk("R7 R9 ctrl", v, 32'h2);
    wr(12'h030, 32'h0); rd(12'h030, v); chk("R7 ctrl clear", v, 0);
    rd(12'h100, v); chk("R9 unmapped", v, 0);

    // R2 sticky + write to raw ignored
    pulse(7'h41);
    repeat (3) @(negedge clk);
    rd(12'h050, v); chk("R2 sticky", v, 32'h41);
    wr(12'h050, 32'h0); rd(12'h050, v); chk("R2 raw write ignored", v, 32'h41);

    // R10 registered read: rdata holds until the next edge
    @(negedge clk); addr = 12'h054; #2;
    chk("R10 rdata before edge", rdata, 32'h41);
    @(negedge clk); chk("R10 rdata after edge", rdata, 32'h35);

    // R5 partial clear
    pulse(7'h7F);
    wr(12'h058, 32'h0000_0005); rd(12'h050, v); chk("R5 partial clear", v, 32'h7A);
    wr(12'h058, 32'h0); rd(12'h050, v); chk("R5 zero write", v, 32'h7A);

    // R6 set wins over clear in the same cycle
    wr(12'h058, 32'h7F);
    @(negedge clk); evt = 7'h08; addr = 12'h058; we = 1'b1; wdata = 32'h7F;
    @(negedge clk); evt = '0; we = 1'b0; wdata = '0;
    rd(12'h050, v); chk("R6 set wins", v, 32'h08);

    // R4 R7 R8 sweep: every raw pattern x enable patterns x routing
    for (int r = 0; r < 2; r++) begin
      wr(12'h030, r ? 32'h2 : 32'h0);
      for (int p = 0; p < 128; p++) begin
        for (int k = 0; k < 4; k++) begin
          e = 7'(p);
          case (k)
            0: m = 7'h7F;
            1: m = 7'h55;
            2: m = 7'h2A;
            default: m = e ^ 7'h7F;
          endcase
          wr(12'h058, 32'h7F);
          wr(12'h054, {25'b0, m});
          pulse(e);
          rd(12'h050, v); chk("R2 raw sweep", v, {25'b0, e});
          rd(12'h058, v);
          chk("R4 R7 masked sweep", v, {25'b0, e & m & (r ? 7'h7D : 7'h7F)});
          chk("R8 irq sweep", {31'b0, irq}, {31'b0, |(e & m & (r ? 7'h7D : 7'h7F))});
        end
      end
    end

    // R7 raw brown-out still sets while routed
    wr(12'h030, 32'h2); wr(12'h058, 32'h7F); wr(12'h054, 32'h02);
    pulse(7'h02);
    rd(12'h050, v); chk("R7 raw bor set", v, 32'h02);
    chk("R7 no irq", {31'b0, irq}, 0);
    wr(12'h030, 32'h0);
    rd(12'h058, v); chk("R7 unrouted masked", v, 32'h02);
    chk("R8 irq after unroute", {31'b0, irq}, 1);
    wr(12'h058, 32'h02);
    @(negedge clk);
    chk("R5 R8 irq cleared", {31'b0, irq}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule